// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block turns the system clock into the bit-time grid of a CAN node. A prescaler divides the clock into time-quantum ticks. A sequencer walks each bit through a one-quantum synchronization segment, a first timing segment that spans the propagation and phase-1 lengths, and a second timing segment that spans the phase-2 length. It raises a transmit-point strobe when a bit starts and a sample strobe at the sample point. The sample point is the end of the first timing segment, so it sits at (1 + TSEG1) / (1 + TSEG1 + TSEG2) of the bit. As a worked case, a 10 MHz quantum rate at 500 kbit/s gives a 20-quantum bit, and TSEG1 = 15 with TSEG2 = 4 places the sample point at 80 %.

The receive line passes through a two-stage synchronizer. Recessive-to-dominant transitions (1 to 0) steer the grid. While the bus is idle, such a transition forces a hard synchronization that restarts the bit. Otherwise it triggers a resynchronization. An edge late in the bit lengthens the first segment, and an edge inside phase 2 shortens the second segment. Each correction is limited by a programmable jump width and by the measured error, and only one correction is made per bit. Frame handling, stuffing, CRC and arbitration are left to the surrounding controller.

Top module: `can_bit_timer`

## Requirements
- R1: `tq_tick_o` is high for one cycle in every `prescale_i` clock cycles. A prescale value of 0 acts as 1.
- R2: With no falling receive edge, `tx_point_o` pulses every `prescale_i * (1 + prop_seg_i + phase1_i + phase2_i)` cycles. Each pulse comes in the first cycle of a synchronization quantum. Each segment field encodes its length in quanta, with 1 to 8 legal.
- R3: Exactly one `sample_o` pulse occurs per uncorrected bit, `prescale_i * (1 + prop_seg_i + phase1_i + E)` cycles after `tx_point_o`, where E is the lengthening from R4 (0 otherwise). In that cycle `rx_bit_o` shows the synchronized receive level. `sample_o` and `tx_point_o` never coincide.
- R4: A falling edge on `rx_i` reaches the edge detector two cycles after `rx_i` falls, and it is charged to the quantum in which it is detected. If that quantum is index k (from 0) of the first timing segment, the segment is lengthened by min(k + 1, `jump_width_i`) quanta. `jump_width_i` encodes 1 to 4.
- R5: If that quantum is index k (from 0) of the second timing segment of length P2, the segment is cut by min(P2 - 1 - k, `jump_width_i`) quanta.
- R6: A falling edge in the synchronization quantum changes no timing. Rising edges on `rx_i` never change timing.
- R7: After the first falling edge of a bit (in any segment), later falling edges in the same bit change no timing unless the bus is idle.
- R8: With `bus_idle_i` high, a falling edge detected in any quantum ends the bit at that quantum's tick. `tx_point_o` pulses in the next cycle, and the next quantum is a synchronization quantum. A sample point that has not yet been reached in that bit is skipped.
- R9: During reset `tq_tick_o`, `sample_o` and `tx_point_o` are low, and `rx_bit_o` is high (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Receive line, 0 = dominant |
| bus_idle_i | input | 1 | High while the bus is idle; selects hard synchronization |
| prescale_i | input | BRP_W | Clock cycles per time quantum |
| prop_seg_i | input | SEG_W | Propagation segment length in quanta |
| phase1_i | input | SEG_W | Phase segment 1 length in quanta |
| phase2_i | input | SEG_W | Phase segment 2 length in quanta |
| jump_width_i | input | SJW_W | Largest correction per resynchronization, in quanta |
| tq_tick_o | output | 1 | One-cycle pulse at the last cycle of every quantum |
| sample_o | output | 1 | One-cycle pulse at the sample point |
| tx_point_o | output | 1 | One-cycle pulse at the start of each bit |
| rx_bit_o | output | 1 | Receive level captured at the last sample point |

## Verification
The strobes are registered behind the quantum tick, so each one appears one cycle after the tick that ends its quantum. A bit that starts at cycle 0 therefore has its sample at `prescale * (1 + TSEG1 + E)` and its next transmit point at `prescale * bit quanta`. A receive pulse driven at cycle `prescale * j` of a bit reaches the detector two cycles later, which is still inside quantum j whenever the prescale is at least 3. The bench counts cycles from each transmit-point pulse, samples between clock edges and compares these offsets with values it derives from the segment lengths. It sweeps every edge position of several configurations, then runs directed cases for repeated edges, held dominant levels and idle-bus restarts.

// File: rtl/can_bt_pkg.sv
`timescale 1ns/1ps
package can_bt_pkg;

    // Segment currently being timed inside a bit
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_ONE  = 2'd1,
        SEG_TWO  = 2'd2
    } seg_e;

endpackage

// File: rtl/can_bt_prescaler.sv
`timescale 1ns/1ps
module can_bt_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] brp_i,
    output logic             tick_o
);

    logic [BRP_W-1:0] lim;
    logic [BRP_W-1:0] cnt_d, cnt_q;
    logic             tick;

    always_comb begin
        lim   = (brp_i == '0) ? '0 : brp_i - BRP_W'(1);
        tick  = (cnt_q >= lim);
        cnt_d = tick ? '0 : cnt_q + BRP_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = tick && rst_n;

    // A quantum longer than one cycle never yields back-to-back ticks
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && brp_i > BRP_W'(1)) |=> (!tick_o || brp_i <= BRP_W'(1)));

endmodule

// File: rtl/can_bt_rxsync.sv
`timescale 1ns/1ps
module can_bt_rxsync (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic rx_o,
    output logic fall_o
);

    // [0] first stage, [1] second stage, [2] previous synchronized level
    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[1:0], rx_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= 3'b111;
        else        sh_q <= sh_d;
    end

    assign rx_o   = sh_q[1];
    assign fall_o = sh_q[2] & ~sh_q[1];

    // A detected falling edge reflects a dominant level two cycles earlier
    assert_fall_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> ($past(rx_i, 2) == 1'b0));

endmodule

// File: rtl/can_bt_seq.sv
`timescale 1ns/1ps
module can_bt_seq
    import can_bt_pkg::*;
#(
    parameter int SEG_W = 4,
    parameter int SJW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             fall_i,
    input  logic             rx_i,
    input  logic             idle_i,
    input  logic [SEG_W-1:0] prop_i,
    input  logic [SEG_W-1:0] ph1_i,
    input  logic [SEG_W-1:0] ph2_i,
    input  logic [SJW_W-1:0] sjw_i,
    output logic             sample_o,
    output logic             txpt_o,
    output logic             bit_o
);

    localparam int CNT_W = SEG_W + 2;

    typedef struct packed {
        seg_e             seg;
        logic [CNT_W-1:0] cnt;   // quantum index inside the segment
        logic [CNT_W-1:0] ext;   // lengthening applied to segment one
        logic             done;  // a correction already used in this bit
        logic             pend;  // edge seen since the last tick
        logic             smp;
        logic             txp;
        logic             bitv;
    } st_t;

    localparam st_t ST_RST = '{seg: SEG_SYNC, cnt: '0, ext: '0, done: 1'b0,
                               pend: 1'b0, smp: 1'b0, txp: 1'b0, bitv: 1'b1};

    st_t q, d;

    logic [CNT_W-1:0] len1, len2, jw, err1, ext_new, rem2, cut2, nxt2;
    logic             edge_now, act;

    always_comb begin
        len1     = CNT_W'(prop_i) + CNT_W'(ph1_i);
        len2     = CNT_W'(ph2_i);
        jw       = CNT_W'(sjw_i);
        edge_now = q.pend | fall_i;
        act      = edge_now & ~q.done;

        // positive error: quanta elapsed after the sync quantum
        err1    = q.cnt + CNT_W'(1);
        ext_new = q.ext;
        if (act && q.seg == SEG_ONE) begin
            ext_new = (err1 < jw) ? err1 : jw;
        end

        // negative error: quanta still left in segment two after this one
        rem2 = ((q.cnt + CNT_W'(1)) < len2) ? (len2 - q.cnt - CNT_W'(1)) : '0;
        cut2 = '0;
        if (act) begin
            cut2 = (rem2 < jw) ? rem2 : jw;
        end
        nxt2 = q.cnt + CNT_W'(1) + cut2;

        d      = q;
        d.smp  = 1'b0;
        d.txp  = 1'b0;
        d.pend = edge_now;

        if (tick_i) begin
            d.pend = 1'b0;
            if (edge_now && idle_i) begin
                d.seg  = SEG_SYNC;
                d.cnt  = '0;
                d.ext  = '0;
                d.done = 1'b0;
                d.txp  = 1'b1;
            end else begin
                unique case (q.seg)
                    SEG_SYNC: begin
                        d.seg = SEG_ONE;
                        d.cnt = '0;
                        if (act) d.done = 1'b1;
                    end
                    SEG_ONE: begin
                        d.ext = ext_new;
                        if (act) d.done = 1'b1;
                        if (err1 >= len1 + ext_new) begin
                            d.seg  = SEG_TWO;
                            d.cnt  = '0;
                            d.smp  = 1'b1;
                            d.bitv = rx_i;
                        end else begin
                            d.cnt = err1;
                        end
                    end
                    default: begin
                        if (act) d.done = 1'b1;
                        if (nxt2 >= len2) begin
                            d.seg  = SEG_SYNC;
                            d.cnt  = '0;
                            d.ext  = '0;
                            d.done = 1'b0;
                            d.txp  = 1'b1;
                        end else begin
                            d.cnt = nxt2;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ST_RST;
        else        q <= d;
    end

    assign sample_o = q.smp;
    assign txpt_o   = q.txp;
    assign bit_o    = q.bitv;

    logic [CNT_W-1:0] ext_mon;
    assign ext_mon = q.ext;

    assert_sample_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> $past(tick_i));

    assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_o && txpt_o));

    assert_ext_within_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mon <= jw);

    assert_single_correction_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && q.done && q.seg == SEG_ONE && !idle_i) |=> $stable(ext_mon));

    assert_hard_sync_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (q.pend || fall_i) && idle_i) |=> (txpt_o && !sample_o));

endmodule

// File: rtl/can_bit_timer.sv
`timescale 1ns/1ps
module can_bit_timer #(
    parameter int BRP_W = 6,
    parameter int SEG_W = 4,
    parameter int SJW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic             bus_idle_i,
    input  logic [BRP_W-1:0] prescale_i,
    input  logic [SEG_W-1:0] prop_seg_i,
    input  logic [SEG_W-1:0] phase1_i,
    input  logic [SEG_W-1:0] phase2_i,
    input  logic [SJW_W-1:0] jump_width_i,
    output logic             tq_tick_o,
    output logic             sample_o,
    output logic             tx_point_o,
    output logic             rx_bit_o
);

    logic tick;
    logic rx_sync;
    logic rx_fall;

    can_bt_prescaler #(.BRP_W(BRP_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .brp_i (prescale_i),
        .tick_o(tick)
    );

    can_bt_rxsync u_rxsync (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_i  (rx_i),
        .rx_o  (rx_sync),
        .fall_o(rx_fall)
    );

    can_bt_seq #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .fall_i  (rx_fall),
        .rx_i    (rx_sync),
        .idle_i  (bus_idle_i),
        .prop_i  (prop_seg_i),
        .ph1_i   (phase1_i),
        .ph2_i   (phase2_i),
        .sjw_i   (jump_width_i),
        .sample_o(sample_o),
        .txpt_o  (tx_point_o),
        .bit_o   (rx_bit_o)
    );

    assign tq_tick_o = tick;

endmodule

// File: tb/can_bit_timer_tb.sv
`timescale 1ns/1ps
module can_bit_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       idle = 1'b0;
    logic [5:0] brp_s;
    logic [3:0] prop_s, ph1_s, ph2_s;
    logic [2:0] sjw_s;
    logic       tq_tick, smp, txp, rxbit;

    int checks = 0;
    int errors = 0;
    int brp, l1, l2, sjw;

    always #2.5 clk = ~clk;

    can_bit_timer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_i        (rx),
        .bus_idle_i  (idle),
        .prescale_i  (brp_s),
        .prop_seg_i  (prop_s),
        .phase1_i    (ph1_s),
        .phase2_i    (ph2_s),
        .jump_width_i(sjw_s),
        .tq_tick_o   (tq_tick),
        .sample_o    (smp),
        .tx_point_o  (txp),
        .rx_bit_o    (rxbit)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int b, input int p, input int a, input int c, input int j);
        brp = b; l1 = p + a; l2 = c; sjw = j;
        brp_s = 6'(b); prop_s = 4'(p); ph1_s = 4'(a); ph2_s = 4'(c); sjw_s = 3'(j);
    endtask

    // Starts in the cycle of a tx_point pulse; ends in the cycle of the next one.
    task automatic run_bit(input int e1, input int hold, input int e2,
                           output int ns, output int nb, output int nt, output int sb);
        ns = -1; nb = -1; nt = 0; sb = -1;
        for (int n = 0; n < 4000; n++) begin
            rx = !((e1 >= 0 && n >= e1 * brp && n < e1 * brp + hold) ||
                   (e2 >= 0 && n == e2 * brp));
            if (n > 0 && tq_tick) nt++;
            if (n > 0 && smp) begin ns = n; sb = int'(rxbit); end
            if (n > 0 && txp) begin nb = n; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        #(5.0 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ns, nb, nt, sb;
        int brps[2] = '{3, 5};
        int pv[4]   = '{1, 2, 8, 3};
        int av[4]   = '{1, 3, 8, 4};
        int cv[4]   = '{1, 4, 8, 2};
        int jv[3]   = '{1, 2, 4};

        set_cfg(4, 2, 3, 4, 2);
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 tick", int'(tq_tick), 0);
        chk("R9 sample", int'(smp), 0);
        chk("R9 txpoint", int'(txp), 0);
        chk("R9 rxbit", int'(rxbit), 1);
        rst_n = 1'b1;
        while (!txp) @(negedge clk);

        // Sweep of edge positions over several configurations (R1..R5)
        foreach (brps[bi]) foreach (pv[si]) foreach (jv[ji]) begin
            set_cfg(brps[bi], pv[si], av[si], cv[si], jv[ji]);
            for (int j = -1; j <= l1 + l2; j++) begin
                int ext, cut, k, r;
                ext = 0; cut = 0;
                if (j >= 1 && j <= l1) ext = (j < sjw) ? j : sjw;
                if (j > l1) begin
                    k = j - 1 - l1;
                    r = l2 - 1 - k;
                    cut = (r < sjw) ? r : sjw;
                end
                run_bit(j, 1, -1, ns, nb, nt, sb);
                if (j <= 0) begin
                    chk("R2 bit length", nb, brp * (1 + l1 + l2));
                end else if (j <= l1) begin
                    chk("R4 lengthened bit", nb, brp * (1 + l1 + ext + l2));
                end else begin
                    chk("R5 shortened bit", nb, brp * (1 + l1 + l2 - cut));
                end
                chk("R3 sample offset", ns, brp * (1 + l1 + ext));
                chk("R1 ticks per bit", nt, 1 + l1 + ext + l2 - cut);
            end
        end

        // R3/R6: held dominant from the sync quantum is sampled, timing unchanged
        set_cfg(4, 2, 3, 4, 2);
        run_bit(0, 4 * 7, -1, ns, nb, nt, sb);
        chk("R6 sync edge and rising edge", nb, 40);
        chk("R3 sample offset dominant", ns, 24);
        chk("R3 sampled dominant", sb, 0);
        run_bit(-1, 1, -1, ns, nb, nt, sb);
        chk("R3 sampled recessive", sb, 1);

        // R7: only the first edge of a bit corrects
        run_bit(1, 1, 3, ns, nb, nt, sb);
        chk("R7 two edges in segment one", nb, 44);
        chk("R7 sample after single lengthening", ns, 28);
        run_bit(0, 1, 2, ns, nb, nt, sb);
        chk("R7 sync edge then segment one edge", nb, 40);
        run_bit(1, 1, 9, ns, nb, nt, sb);
        chk("R7 segment one edge then segment two edge", nb, 44);

        // R8: hard synchronization while idle
        idle = 1'b1;
        run_bit(-1, 1, -1, ns, nb, nt, sb);
        chk("R8 idle without edge", nb, 40);
        for (int j = 0; j <= l1 + l2; j++) begin
            run_bit(j, 1, -1, ns, nb, nt, sb);
            chk("R8 restart point", nb, brp * (j + 1));
            chk("R8 sample kept or skipped", ns, (j > l1) ? brp * (1 + l1) : -1);
        end
        idle = 1'b0;
        run_bit(-1, 1, -1, ns, nb, nt, sb);
        chk("R2 nominal after idle", nb, 40);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule